// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Flags

This block is one general-purpose I/O port of up to 32 pins, reached over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Software never writes a control latch directly. Each latch has a set alias and a clear alias, and a write changes only the bit positions that carry a 1. The port holds six latches: output data, pull-up disable, interrupt mask, interrupt select, direction and trigger mode. It also has a read-only view of the synchronized pins and a read-only flag register.

A pin whose select bit is set leaves GPIO duty and becomes an interrupt source. Its trigger bit picks edge detection (1) or level detection (0). Its direction bit then sets the polarity: 1 means rising edge or high level, and 0 means falling edge or low level. Detected events are held in the flag register. One interrupt line is the OR of the flags whose mask bit is clear. The lowest-numbered pending flag is reported as an index with a valid bit. The flag-clear alias uses the same address as the data-set alias, and each written bit goes to one of the two according to that pin's select bit.

The pin count is a parameter. Bit positions at and above it read as zero and never hold state.

Top module: `gpio_irq_port`

## Requirements
- R1: Offset 0x10 reads the data latch, 0x14 sets it and 0x18 clears it. Only bits written as 1 change. `gpio_out` equals the latch.
- R2: Offset 0x30 reads the pull latch, 0x34 sets it and 0x38 clears it. A 1 disables the pin's pull-up, and `pull_off` equals the latch.
- R3: Offset 0x20 reads the interrupt mask, 0x24 sets it and 0x28 clears it. A 1 masks that pin.
- R4: The select latch uses 0x50/0x54/0x58, direction uses 0x60/0x64/0x68 and trigger uses 0x70/0x74/0x78, each as read/set/clear. `gpio_oe` is direction AND NOT select.
- R5: Offset 0x00 reads the pin inputs through a two-flop synchronizer. A change on the pin is visible two clock edges later.
- R6: With select=1 and trigger=1, direction=1 flags a rising edge and direction=0 flags a falling edge. An edge sets the flag on the third clock edge after the pin changes. A steady pin or the opposite edge sets nothing.
- R7: With select=1 and trigger=0, the flag sets while the pin is at its active level (direction=1 high, 0 low). A clear wins in its own cycle, and the flag re-asserts on the next edge if the level is still present.
- R8: A write to 0x14 clears the flag of every written pin whose select bit is 1. It sets the data bit only for written pins whose select bit is 0.
- R9: A flag is forced to 0 on the edge after its pin's select bit is 0. The flag register reads at 0x80.
- R10: `irq` is 1 exactly when some flag is set whose mask bit is 0.
- R11: `pend_idx` is the lowest-numbered set flag, masked or not. `pend_valid` is 1 exactly when any flag is set.
- R12: Reset clears every latch, the synchronizer and every flag, so all registers read 0.
- R13: Bits at and above `PIN_COUNT` read as 0 at every offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset within the port |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (bit mask for the set and clear aliases) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | PIN_COUNT | Asynchronous pin inputs |
| gpio_out | output | PIN_COUNT | Output data latch |
| gpio_oe | output | PIN_COUNT | Output enable per pin |
| pull_off | output | PIN_COUNT | Pull-up disable per pin |
| irq | output | 1 | Combined unmasked interrupt |
| pend_idx | output | $clog2(PIN_COUNT) | Lowest pending flag index |
| pend_valid | output | 1 | Any flag pending |

## Verification
The assertions check on every cycle the invariants between separately built pieces. These are: no flag outlives its select bit, a shared-address write always empties the selected flags it names, `irq` never rises without a pending index, and the index points at the lowest set flag. Output enable never covers a selected pin, and unimplemented read bits stay zero. Only the bench scenarios can show the timing and polarity properties. These include the two-edge synchronizer delay, the third-edge flag for an edge, ignored opposite edges, and the one-cycle dip and re-assert of a level flag after a clear. They also include routing of a 0x14 write to data versus flags.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    localparam int OFF_W = 8;
    localparam int BUS_W = 32;

    // register offsets (set alias = base + 4, clear alias = base + 8)
    localparam logic [OFF_W-1:0] OFF_PIN     = 8'h00;
    localparam logic [OFF_W-1:0] OFF_DAT     = 8'h10;
    localparam logic [OFF_W-1:0] OFF_DAT_SET = 8'h14;
    localparam logic [OFF_W-1:0] OFF_DAT_CLR = 8'h18;
    localparam logic [OFF_W-1:0] OFF_MSK     = 8'h20;
    localparam logic [OFF_W-1:0] OFF_MSK_SET = 8'h24;
    localparam logic [OFF_W-1:0] OFF_MSK_CLR = 8'h28;
    localparam logic [OFF_W-1:0] OFF_PUL     = 8'h30;
    localparam logic [OFF_W-1:0] OFF_PUL_SET = 8'h34;
    localparam logic [OFF_W-1:0] OFF_PUL_CLR = 8'h38;
    localparam logic [OFF_W-1:0] OFF_SEL     = 8'h50;
    localparam logic [OFF_W-1:0] OFF_SEL_SET = 8'h54;
    localparam logic [OFF_W-1:0] OFF_SEL_CLR = 8'h58;
    localparam logic [OFF_W-1:0] OFF_DIR     = 8'h60;
    localparam logic [OFF_W-1:0] OFF_DIR_SET = 8'h64;
    localparam logic [OFF_W-1:0] OFF_DIR_CLR = 8'h68;
    localparam logic [OFF_W-1:0] OFF_TRG     = 8'h70;
    localparam logic [OFF_W-1:0] OFF_TRG_SET = 8'h74;
    localparam logic [OFF_W-1:0] OFF_TRG_CLR = 8'h78;
    localparam logic [OFF_W-1:0] OFF_FLG     = 8'h80;

    // latch group indices
    localparam int GRP_DAT = 0;
    localparam int GRP_MSK = 1;
    localparam int GRP_PUL = 2;
    localparam int GRP_SEL = 3;
    localparam int GRP_DIR = 4;
    localparam int GRP_TRG = 5;
    localparam int NUM_GRP = 6;
    localparam int GRP_W   = 3;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SET,
        ACC_CLR
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [GRP_W-1:0] grp;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic [OFF_W-1:0] off);
        wr_dec_t d;
        d.kind = ACC_NONE;
        d.grp  = '0;
        unique case (off)
            OFF_DAT_SET: begin d.kind = ACC_SET; d.grp = GRP_W'(GRP_DAT); end
            OFF_DAT_CLR: begin d.kind = ACC_CLR; d.grp = GRP_W'(GRP_DAT); end
            OFF_MSK_SET: begin d.kind = ACC_SET; d.grp = GRP_W'(GRP_MSK); end
            OFF_MSK_CLR: begin d.kind = ACC_CLR; d.grp = GRP_W'(GRP_MSK); end
            OFF_PUL_SET: begin d.kind = ACC_SET; d.grp = GRP_W'(GRP_PUL); end
            OFF_PUL_CLR: begin d.kind = ACC_CLR; d.grp = GRP_W'(GRP_PUL); end
            OFF_SEL_SET: begin d.kind = ACC_SET; d.grp = GRP_W'(GRP_SEL); end
            OFF_SEL_CLR: begin d.kind = ACC_CLR; d.grp = GRP_W'(GRP_SEL); end
            OFF_DIR_SET: begin d.kind = ACC_SET; d.grp = GRP_W'(GRP_DIR); end
            OFF_DIR_CLR: begin d.kind = ACC_CLR; d.grp = GRP_W'(GRP_DIR); end
            OFF_TRG_SET: begin d.kind = ACC_SET; d.grp = GRP_W'(GRP_TRG); end
            OFF_TRG_CLR: begin d.kind = ACC_CLR; d.grp = GRP_W'(GRP_TRG); end
            default:     begin d.kind = ACC_NONE; d.grp = '0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_setclr_latch.sv
`timescale 1ns/1ps
module gpio_setclr_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q | set_bits) & ~clr_bits;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= raw;
            cur    <= meta_q;
            prev   <= cur;
        end
    end

endmodule

// File: rtl/gpio_event_flags.sv
`timescale 1ns/1ps
module gpio_event_flags #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] pol_hi,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] flags
);

    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_w;
        logic fall_w;
        logic lvl_w;

        assign rise_w = cur[i] & ~prev[i];
        assign fall_w = ~cur[i] & prev[i];
        assign lvl_w  = pol_hi[i] ? cur[i] : ~cur[i];
        assign hit[i] = edge_mode[i] ? (pol_hi[i] ? rise_w : fall_w) : lvl_w;

        // clear and deselect win over a new event
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (!sel[i] || clr_bits[i]) begin
                flags[i] <= 1'b0;
            end else if (hit[i]) begin
                flags[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpio_lowest_pend.sv
`timescale 1ns/1ps
module gpio_lowest_pend #(
    parameter int W     = 32,
    parameter int IDX_W = 5
) (
    input  logic [W-1:0]     flags,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (flags[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT = 32,
    localparam int IDX_W    = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OFF_W-1:0]     bus_addr,
    input  logic                 bus_wr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] gpio_out,
    output logic [PIN_COUNT-1:0] gpio_oe,
    output logic [PIN_COUNT-1:0] pull_off,
    output logic                 irq,
    output logic [IDX_W-1:0]     pend_idx,
    output logic                 pend_valid
);

    localparam int W = PIN_COUNT;

    wr_dec_t      dec;
    logic [W-1:0] wbits;
    logic [W-1:0] set_m [NUM_GRP];
    logic [W-1:0] clr_m [NUM_GRP];
    logic [W-1:0] lat_q [NUM_GRP];
    logic [W-1:0] sel_q;
    logic [W-1:0] flag_q;
    logic [W-1:0] flag_clr;
    logic [W-1:0] pin_cur;
    logic [W-1:0] pin_prev;
    logic [W-1:0] rd_w;

    assign wbits = bus_wdata[W-1:0];

    always_comb begin
        if (bus_wr) begin
            dec = decode_write(bus_addr);
        end else begin
            dec = '{kind: ACC_NONE, grp: '0};
        end
    end

    assign sel_q = lat_q[GRP_SEL];

    // shared 0x14 alias: selected pins clear flags, the rest set data
    assign flag_clr = (dec.kind == ACC_SET && dec.grp == GRP_W'(GRP_DAT)) ? (wbits & sel_q) : '0;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lat
        logic hit_set;
        logic hit_clr;
        assign hit_set = (dec.kind == ACC_SET) && (dec.grp == GRP_W'(g));
        assign hit_clr = (dec.kind == ACC_CLR) && (dec.grp == GRP_W'(g));
        if (g == GRP_DAT) begin : g_dat
            assign set_m[g] = hit_set ? (wbits & ~sel_q) : '0;
        end else begin : g_oth
            assign set_m[g] = hit_set ? wbits : '0;
        end
        assign clr_m[g] = hit_clr ? wbits : '0;

        gpio_setclr_latch #(.W(W)) u_lat (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_m[g]),
            .clr_bits (clr_m[g]),
            .q        (lat_q[g])
        );
    end

    gpio_in_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .cur   (pin_cur),
        .prev  (pin_prev)
    );

    gpio_event_flags #(.W(W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (pin_cur),
        .prev      (pin_prev),
        .sel       (sel_q),
        .pol_hi    (lat_q[GRP_DIR]),
        .edge_mode (lat_q[GRP_TRG]),
        .clr_bits  (flag_clr),
        .flags     (flag_q)
    );

    gpio_lowest_pend #(.W(W), .IDX_W(IDX_W)) u_pend (
        .flags (flag_q),
        .idx   (pend_idx),
        .valid (pend_valid)
    );

    assign gpio_out = lat_q[GRP_DAT];
    assign pull_off = lat_q[GRP_PUL];
    assign gpio_oe  = lat_q[GRP_DIR] & ~sel_q;
    assign irq      = |(flag_q & ~lat_q[GRP_MSK]);

    always_comb begin
        unique case (bus_addr)
            OFF_PIN: rd_w = pin_cur;
            OFF_DAT: rd_w = lat_q[GRP_DAT];
            OFF_MSK: rd_w = lat_q[GRP_MSK];
            OFF_PUL: rd_w = lat_q[GRP_PUL];
            OFF_SEL: rd_w = lat_q[GRP_SEL];
            OFF_DIR: rd_w = lat_q[GRP_DIR];
            OFF_TRG: rd_w = lat_q[GRP_TRG];
            OFF_FLG: rd_w = flag_q;
            default: rd_w = '0;
        endcase
    end

    always_comb begin
        bus_rdata        = '0;
        bus_rdata[W-1:0] = rd_w;
    end

endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT = 32,
    parameter int IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [OFF_W-1:0]     bus_addr,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic [PIN_COUNT-1:0] gpio_oe,
    input logic                 irq,
    input logic [IDX_W-1:0]     pend_idx,
    input logic                 pend_valid,
    input logic [PIN_COUNT-1:0] flags,
    input logic [PIN_COUNT-1:0] sel
);

    localparam int W = PIN_COUNT;
    localparam logic [BUS_W-1:0] IMPL = (W >= BUS_W) ? '1 : ((BUS_W'(1) << W) - BUS_W'(1));

    AST_NO_ORPHAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(sel)) == '0)); // R9

    AST_SHARED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_DAT_SET) |=> ((flags & $past(bus_wdata[W-1:0] & sel)) == '0)); // R8

    AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend_valid); // R10

    AST_PEND_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (flags[pend_idx] && ((flags & ((W'(1) << pend_idx) - W'(1))) == '0))); // R11

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (flags == '0)); // R11

    AST_OE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_oe & sel) == '0); // R4

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL) == '0); // R13

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PIN_COUNT(PIN_COUNT), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .gpio_oe    (gpio_oe),
    .irq        (irq),
    .pend_idx   (pend_idx),
    .pend_valid (pend_valid),
    .flags      (flag_q),
    .sel        (sel_q)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;

    localparam int N = 28;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  gpio_out;
    logic [N-1:0]  gpio_oe;
    logic [N-1:0]  pull_off;
    logic          irq;
    logic [IW-1:0] pend_idx;
    logic          pend_valid;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    gpio_irq_port #(.PIN_COUNT(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .gpio_out   (gpio_out),
        .gpio_oe    (gpio_oe),
        .pull_off   (pull_off),
        .irq        (irq),
        .pend_idx   (pend_idx),
        .pend_valid (pend_valid)
    );

    // {write offset, write data, read offset, expected read}
    localparam logic [79:0] VEC [12] = '{
        {8'h14, 32'hFFFF_FFFF, 8'h10, 32'h0FFF_FFFF},  // R1, R13 upper bits absent
        {8'h18, 32'h0000_FF00, 8'h10, 32'h0FFF_00FF},  // R1
        {8'h34, 32'h0000_0005, 8'h30, 32'h0000_0005},  // R2
        {8'h38, 32'h0000_0001, 8'h30, 32'h0000_0004},  // R2
        {8'h24, 32'h0000_F000, 8'h20, 32'h0000_F000},  // R3
        {8'h28, 32'h0000_3000, 8'h20, 32'h0000_C000},  // R3
        {8'h64, 32'h0000_00F0, 8'h60, 32'h0000_00F0},  // R4
        {8'h68, 32'h0000_0030, 8'h60, 32'h0000_00C0},  // R4
        {8'h74, 32'h0000_0011, 8'h70, 32'h0000_0011},  // R4
        {8'h78, 32'h0000_0001, 8'h70, 32'h0000_0010},  // R4
        {8'h54, 32'h0000_0300, 8'h50, 32'h0000_0300},  // R4
        {8'h58, 32'h0000_0100, 8'h50, 32'h0000_0200}   // R4
    };

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h10:   return "R1";
            8'h30:   return "R2";
            8'h20:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        settle(2);
        rst_n = 1'b1;

        for (int k = 0; k < 12; k++) begin
            wr(VEC[k][79:72], VEC[k][71:40]);
            rd(VEC[k][39:32], r);
            check(tag_of(VEC[k][39:32]), r, VEC[k][31:0]);
        end

        // R12: reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        settle(1);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] offs [8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h50, 8'h60, 8'h70, 8'h80};
            rd(offs[k], r);
            check("R12", r, 32'h0);
        end
        check("R12", {31'b0, pend_valid}, 32'h0);

        // R5 / R13: two-flop pin view
        pin_in = '1;
        settle(1);
        rd(8'h00, r);
        check("R5", r, 32'h0);
        settle(1);
        rd(8'h00, r);
        check("R13", r, 32'h0FFF_FFFF);
        pin_in = '0;
        settle(3);

        // R4 output enable, R1 output pins, R2 pull output
        wr(8'h64, 32'h3);
        check("R4", 32'(gpio_oe), 32'h3);
        wr(8'h54, 32'h2);
        check("R4", 32'(gpio_oe), 32'h1);
        wr(8'h58, 32'h2);
        wr(8'h68, 32'h3);
        wr(8'h14, 32'h5);
        check("R1", 32'(gpio_out), 32'h5);
        wr(8'h18, 32'h5);
        wr(8'h34, 32'h10);
        check("R2", 32'(pull_off), 32'h10);
        wr(8'h38, 32'h10);

        // R6 rising edge on pin 3
        wr(8'h64, 32'h8);
        wr(8'h74, 32'h8);
        wr(8'h54, 32'h8);
        rd(8'h80, r);
        check("R6", r, 32'h0);
        pin_in[3] = 1'b1;
        settle(2);
        rd(8'h80, r);
        check("R6", r, 32'h0);
        settle(1);
        rd(8'h80, r);
        check("R6", r, 32'h8);
        check("R10", {31'b0, irq}, 32'h1);
        check("R11", {26'b0, pend_valid, pend_idx}, {26'b0, 1'b1, 5'd3});
        wr(8'h14, 32'h8);
        rd(8'h80, r);
        check("R8", r, 32'h0);
        rd(8'h10, r);
        check("R8", r, 32'h0);
        settle(4);
        rd(8'h80, r);
        check("R6", r, 32'h0);

        // falling edge ignored, then masked rising edge
        pin_in[3] = 1'b0;
        settle(4);
        rd(8'h80, r);
        check("R6", r, 32'h0);
        wr(8'h24, 32'h8);
        pin_in[3] = 1'b1;
        settle(4);
        rd(8'h80, r);
        check("R6", r, 32'h8);
        check("R10", {31'b0, irq}, 32'h0);
        check("R11", {26'b0, pend_valid, pend_idx}, {26'b0, 1'b1, 5'd3});

        // R7 level-low on pin 5
        wr(8'h54, 32'h20);
        settle(1);
        rd(8'h80, r);
        check("R7", r, 32'h28);
        check("R11", 32'(pend_idx), 32'd3);
        check("R10", {31'b0, irq}, 32'h1);
        wr(8'h14, 32'h8);
        check("R11", 32'(pend_idx), 32'd5);
        wr(8'h14, 32'h20);
        rd(8'h80, r);
        check("R7", r, 32'h0);
        settle(1);
        rd(8'h80, r);
        check("R7", r, 32'h20);
        pin_in[5] = 1'b1;
        settle(3);
        wr(8'h14, 32'h20);
        settle(3);
        rd(8'h80, r);
        check("R7", r, 32'h0);

        // R9 deselected pin raises no flag
        wr(8'h24, 32'h20);
        wr(8'h68, 32'h20);
        wr(8'h58, 32'h20);
        pin_in[5] = 1'b0;
        settle(3);
        rd(8'h80, r);
        check("R9", r, 32'h0);
        check("R11", {31'b0, pend_valid}, 32'h0);

        // R6 falling edge on pin 0
        pin_in[0] = 1'b1;
        settle(3);
        wr(8'h74, 32'h1);
        wr(8'h54, 32'h1);
        rd(8'h80, r);
        check("R6", r, 32'h0);
        pin_in[0] = 1'b0;
        settle(3);
        rd(8'h80, r);
        check("R6", r, 32'h1);
        check("R11", {26'b0, pend_valid, pend_idx}, {26'b0, 1'b1, 5'd0});
        check("R10", {31'b0, irq}, 32'h1);

        summary();
        $finish;
    end

endmodule